// File: doc/BRIEF.md
# Three-Row Matrix-Vector Transform Unit

This block computes three dot products of a 3x3 matrix of signed 16-bit coefficients with a signed 16-bit 3-element vector. A signed 32-bit offset can be added to each row, scaled up by 2^12 first. Each row is accumulated in a 44-bit signed register. Every time a term is added, the register is checked for leaving the 44-bit range, and on overflow it wraps. The finished row sum is then shifted right arithmetically, by 12 or by 0. The low 32 bits of that shifted value are kept as the row result. Each row result is also clamped to a 16-bit range, and the lower bound of that range depends on a limit-mode input.

A pulse on `start_i` launches one transform. The operands and the mode inputs must stay stable until `done_o` pulses. The parameter `NUM_MUL` selects the datapath. With `NUM_MUL = 1`, one multiplier walks all nine products, row 0 first and then rows 1 and 2. With `NUM_MUL = 3`, three multipliers work on the three rows side by side, one column per cycle. Both variants produce the same values and the same flags.

Top module: `mvm_xform`

## Requirements
- R1: With `trans_en_i` = 1 and `shift_fmt_i` = 0, each row result `mac_o[r]` is the low 32 bits of (T_r·4096 + M_r0·V0 + M_r1·V1 + M_r2·V2). M_rc sits in `mat_i[(3r+c)·16 +: 16]`, V_c in `vec_i[16c +: 16]`, T_r in `trans_i[32r +: 32]`, and row r's results sit at `[32r +: 32]` of `mac_o` and `[16r +: 16]` of `ir_o`.
- R2: With `trans_en_i` = 0 the offset term is absent, and each row result is the plain dot product.
- R3: With `shift_fmt_i` = 1, the 44-bit sum is shifted right arithmetically by 12 before its low 32 bits are taken. With 0 it is not shifted.
- R4: The accumulator starts at the scaled offset, and the three products are added in column order 0, 1, 2. If any of these partial sums exceeds 2^43−1, `ovf_pos_o[r]` is set and the sum wraps modulo 2^44.
- R5: If any partial sum drops below −2^43, `ovf_neg_o[r]` is set and the sum wraps. The flag stays set even when the final result looks in range.
- R6: With `lim_mode_i` = 0, `ir_o[r]` is `mac_o[r]` clamped to −32768..32767. `ir_sat_o[r]` is set exactly when clamping occurred.
- R7: With `lim_mode_i` = 1, `ir_o[r]` is clamped to 0..32767, and `ir_sat_o[r]` is set on a clamp.
- R8: `busy_o` is high from the clock edge that samples `start_i` until `done_o` rises. `done_o` is high for exactly one cycle, 9/NUM_MUL + 1 clock edges after the edge that samples `start_i`, with `busy_o` low at that time.
- R9: A `start_i` pulse while `busy_o` is high is ignored. It neither restarts the run nor moves `done_o`.
- R10: All flags clear when a new run starts. While the block is idle, results and flags hold even when the operand inputs change.
- R11: After reset, `busy_o`, `done_o`, all results and all flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Launch a transform when idle |
| shift_fmt_i | input | 1 | 1: shift result right by 12; 0: no shift |
| lim_mode_i | input | 1 | 1: clamp IR to 0..32767; 0: to −32768..32767 |
| trans_en_i | input | 1 | Add the scaled offset vector |
| mat_i | input | 144 | Nine signed 16-bit coefficients, row-major |
| vec_i | input | 48 | Three signed 16-bit vector elements |
| trans_i | input | 96 | Three signed 32-bit offsets |
| busy_o | output | 1 | Transform in progress |
| done_o | output | 1 | One-cycle completion pulse |
| mac_o | output | 96 | Three 32-bit row results |
| ir_o | output | 48 | Three clamped 16-bit results |
| ovf_pos_o | output | 3 | Per-row positive 44-bit overflow, sticky within a run |
| ovf_neg_o | output | 3 | Per-row negative 44-bit overflow, sticky within a run |
| ir_sat_o | output | 3 | Per-row clamp indicator |

## Verification
The hardest state to reach is a 44-bit accumulator overflow. No sum of three 16x16 products comes near 2^43, so overflow needs an offset at the edge of its 32-bit range, scaled by 4096, plus a product that pushes past the limit. The bench drives a full-scale positive offset plus the product (−32768)·(−32768), and a full-scale negative offset minus one. The second case wraps to a final value of −1 that looks harmless, so the sticky negative flag is the only evidence of the overflow.

// File: rtl/mvm_pkg.sv
package mvm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_IRS  = 2'd2
    } mvm_phase_e;

endpackage

// File: rtl/mvm_mul_lane.sv
module mvm_mul_lane #(
    parameter int EW = 16,
    parameter int PW = 32
) (
    input  logic signed [EW-1:0] a_i,
    input  logic signed [EW-1:0] b_i,
    output logic signed [PW-1:0] prod_o
);
    // Full signed product; PW >= 2*EW keeps it exact.
    assign prod_o = PW'(a_i) * PW'(b_i);
endmodule

// File: rtl/mvm_acc_step.sv
module mvm_acc_step #(
    parameter int AW = 44,
    parameter int PW = 32
) (
    input  logic signed [AW-1:0] acc_i,
    input  logic signed [PW-1:0] add_i,
    output logic signed [AW-1:0] acc_o,
    output logic                 ovf_pos_o,
    output logic                 ovf_neg_o
);
    logic signed [AW:0] sum;

    // One guard bit: a mismatch of the top two bits means the sum left the range (R4, R5).
    assign sum       = (AW+1)'(acc_i) + (AW+1)'(add_i);
    assign ovf_pos_o = ~sum[AW] &  sum[AW-1];
    assign ovf_neg_o =  sum[AW] & ~sum[AW-1];
    assign acc_o     = sum[AW-1:0];
endmodule

// File: rtl/mvm_ir_clamp.sv
module mvm_ir_clamp #(
    parameter int MW = 32,
    parameter int IW = 16
) (
    input  logic signed [MW-1:0] mac_i,
    input  logic                 lim_i,
    output logic        [IW-1:0] ir_o,
    output logic                 sat_o
);
    localparam logic signed [MW-1:0] HI = MW'((64'sd1 <<< (IW-1)) - 64'sd1);
    localparam logic signed [MW-1:0] LO = -HI - MW'(1);

    always_comb begin
        ir_o  = mac_i[IW-1:0];
        sat_o = 1'b0;
        if (mac_i > HI) begin
            ir_o  = HI[IW-1:0];
            sat_o = 1'b1;
        end else if (lim_i && (mac_i < 0)) begin        // R7
            ir_o  = '0;
            sat_o = 1'b1;
        end else if (mac_i < LO) begin                  // R6
            ir_o  = LO[IW-1:0];
            sat_o = 1'b1;
        end
    end
endmodule

// File: rtl/mvm_xform.sv
module mvm_xform
    import mvm_pkg::*;
#(
    parameter int EW      = 16,
    parameter int TW      = 32,
    parameter int AW      = 44,
    parameter int MW      = 32,
    parameter int IW      = 16,
    parameter int FRAC_SH = 12,
    parameter int TR_SH   = 12,
    parameter int NUM_MUL = 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start_i,
    input  logic                   shift_fmt_i,
    input  logic                   lim_mode_i,
    input  logic                   trans_en_i,
    input  logic [9*EW-1:0]        mat_i,
    input  logic [3*EW-1:0]        vec_i,
    input  logic [3*TW-1:0]        trans_i,
    output logic                   busy_o,
    output logic                   done_o,
    output logic [3*MW-1:0]        mac_o,
    output logic [3*IW-1:0]        ir_o,
    output logic [2:0]             ovf_pos_o,
    output logic [2:0]             ovf_neg_o,
    output logic [2:0]             ir_sat_o
);
    localparam int DIM      = 3;
    localparam int PW       = 2*EW;
    localparam logic [1:0] LAST_IX = 2'(DIM-1);

    typedef struct packed {
        mvm_phase_e                 phase;
        logic [1:0]                 row;
        logic [1:0]                 col;
        logic [DIM-1:0][AW-1:0]     acc;
        logic [DIM-1:0][MW-1:0]     mac;
        logic [DIM-1:0][IW-1:0]     ir;
        logic [DIM-1:0]             ovp;
        logic [DIM-1:0]             ovn;
        logic [DIM-1:0]             sat;
        logic                       done;
    } st_t;

    st_t q, d;

    // Lane operand selection and arithmetic
    logic        [1:0]    lane_row  [NUM_MUL];
    logic signed [EW-1:0] lane_a    [NUM_MUL];
    logic signed [EW-1:0] lane_b    [NUM_MUL];
    logic signed [AW-1:0] lane_acc  [NUM_MUL];
    logic signed [PW-1:0] lane_prod [NUM_MUL];
    logic signed [AW-1:0] lane_sum  [NUM_MUL];
    logic                 lane_op   [NUM_MUL];
    logic                 lane_on   [NUM_MUL];

    for (genvar l = 0; l < NUM_MUL; l++) begin : g_lane
        // One lane walks the rows in turn; three lanes own one row each.
        if (NUM_MUL == 1) begin : g_seq
            assign lane_row[l] = q.row;
        end else begin : g_par
            assign lane_row[l] = 2'(l);
        end
        assign lane_a[l]   = mat_i[(int'(lane_row[l])*DIM + int'(q.col))*EW +: EW];
        assign lane_b[l]   = vec_i[int'(q.col)*EW +: EW];
        assign lane_acc[l] = q.acc[lane_row[l]];

        mvm_mul_lane #(.EW(EW), .PW(PW)) u_mul (
            .a_i    (lane_a[l]),
            .b_i    (lane_b[l]),
            .prod_o (lane_prod[l])
        );

        mvm_acc_step #(.AW(AW), .PW(PW)) u_acc (
            .acc_i     (lane_acc[l]),
            .add_i     (lane_prod[l]),
            .acc_o     (lane_sum[l]),
            .ovf_pos_o (lane_op[l]),
            .ovf_neg_o (lane_on[l])
        );
    end

    // Clamp stage on the registered row results
    logic [IW-1:0] clamp_ir  [DIM];
    logic          clamp_sat [DIM];

    for (genvar r = 0; r < DIM; r++) begin : g_row
        mvm_ir_clamp #(.MW(MW), .IW(IW)) u_clamp (
            .mac_i (q.mac[r]),
            .lim_i (lim_mode_i),
            .ir_o  (clamp_ir[r]),
            .sat_o (clamp_sat[r])
        );
        assign mac_o[r*MW +: MW] = q.mac[r];
        assign ir_o[r*IW +: IW]  = q.ir[r];
    end

    // Next-state computation
    always_comb begin
        logic signed [AW-1:0] shifted;
        shifted = '0;
        d       = q;
        d.done  = 1'b0;
        unique case (q.phase)
            ST_IDLE: begin
                if (start_i) begin                          // R9: only sampled here
                    d.phase = ST_RUN;
                    d.row   = '0;
                    d.col   = '0;
                    d.ovp   = '0;                           // R10
                    d.ovn   = '0;
                    d.sat   = '0;
                    for (int r = 0; r < DIM; r++) begin     // R1, R2
                        d.acc[r] = trans_en_i
                                 ? (AW'($signed(trans_i[r*TW +: TW])) <<< TR_SH)
                                 : '0;
                    end
                end
            end
            ST_RUN: begin
                for (int l = 0; l < NUM_MUL; l++) begin
                    d.acc[lane_row[l]] = lane_sum[l];
                    d.ovp[lane_row[l]] = q.ovp[lane_row[l]] | lane_op[l];   // R4
                    d.ovn[lane_row[l]] = q.ovn[lane_row[l]] | lane_on[l];   // R5
                    if (q.col == LAST_IX) begin
                        shifted = lane_sum[l] >>> (shift_fmt_i ? FRAC_SH : 0);  // R3
                        d.mac[lane_row[l]] = shifted[MW-1:0];
                    end
                end
                if (q.col == LAST_IX) begin
                    d.col = '0;
                    if ((NUM_MUL == 1) && (q.row != LAST_IX)) begin
                        d.row = q.row + 2'd1;
                    end else begin
                        d.phase = ST_IRS;
                    end
                end else begin
                    d.col = q.col + 2'd1;
                end
            end
            ST_IRS: begin
                for (int r = 0; r < DIM; r++) begin         // R6, R7
                    d.ir[r]  = clamp_ir[r];
                    d.sat[r] = clamp_sat[r];
                end
                d.done  = 1'b1;                             // R8
                d.phase = ST_IDLE;
            end
            default: d.phase = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;                                        // R11
        end else begin
            q <= d;
        end
    end

    assign busy_o    = (q.phase != ST_IDLE);
    assign done_o    = q.done;
    assign ovf_pos_o = q.ovp;
    assign ovf_neg_o = q.ovn;
    assign ir_sat_o  = q.sat;

endmodule

module mvm_xform_chk #(
    parameter int DIM = 3,
    parameter int MW  = 32,
    parameter int IW  = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 start_i,
    input logic                 lim_mode_i,
    input logic                 busy_o,
    input logic                 done_o,
    input logic [DIM*MW-1:0]    mac_o,
    input logic [DIM*IW-1:0]    ir_o,
    input logic [DIM-1:0]       ir_sat_o
);
    AST_BUSY_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);                                   // R8
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);                                                // R8
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);                                                // R8
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> ($stable(mac_o) && $stable(ir_o) && $stable(ir_sat_o))); // R10

    for (genvar r = 0; r < DIM; r++) begin : g_row_chk
        AST_IR_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
            (done_o && lim_mode_i) |-> !ir_o[r*IW + IW - 1]);               // R7
        AST_IR_FOLLOWS_MAC: assert property (@(posedge clk) disable iff (!rst_n)
            (done_o && !ir_sat_o[r]) |-> (ir_o[r*IW +: IW] == mac_o[r*MW +: IW])); // R6
        AST_SAT_AT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
            (done_o && ir_sat_o[r]) |->
            ((ir_o[r*IW +: IW] == {1'b0, {(IW-1){1'b1}}}) ||
             (ir_o[r*IW +: IW] == {1'b1, {(IW-1){1'b0}}}) ||
             (ir_o[r*IW +: IW] == '0)));                                     // R6
    end
endmodule

bind mvm_xform mvm_xform_chk #(.DIM(3), .MW(MW), .IW(IW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .lim_mode_i (lim_mode_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .mac_o      (mac_o),
    .ir_o       (ir_o),
    .ir_sat_o   (ir_sat_o)
);

// File: tb/mvm_xform_tb_top.sv
`timescale 1ns/1ps
module mvm_xform_tb_top;
    localparam int NMUL = 1;
    localparam int LAT  = 9/NMUL + 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0, sf = 1'b0, lm = 1'b0, te = 1'b0;
    logic [143:0] mat = '0;
    logic [47:0]  vec = '0;
    logic [95:0]  tr  = '0;
    logic         busy, done;
    logic [95:0]  mac;
    logic [47:0]  ir;
    logic [2:0]   ovp, ovn, sat;

    always #2.5 clk = ~clk;

    mvm_xform #(.NUM_MUL(NMUL)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start), .shift_fmt_i(sf),
        .lim_mode_i(lm), .trans_en_i(te), .mat_i(mat), .vec_i(vec),
        .trans_i(tr), .busy_o(busy), .done_o(done), .mac_o(mac),
        .ir_o(ir), .ovf_pos_o(ovp), .ovf_neg_o(ovn), .ir_sat_o(sat)
    );

    typedef struct packed {
        logic [0:8][15:0] m;
        logic [0:2][15:0] v;
        logic [0:2][31:0] t;
        logic             sf;
        logic             lm;
        logic             te;
    } vec_t;

    localparam vec_t TBL [6] = '{
        // R1: unit diagonal plus offsets
        '{m:'{16'd1,16'd0,16'd0, 16'd0,16'd1,16'd0, 16'd0,16'd0,16'd1},
          v:'{16'd100,-16'sd200,16'd300}, t:'{32'd1,32'd2,32'd3}, sf:1'b0, lm:1'b0, te:1'b1},
        // R2, R7: offsets ignored, non-negative clamp
        '{m:'{16'd1,16'd0,16'd0, 16'd0,16'd1,16'd0, 16'd0,16'd0,16'd1},
          v:'{16'd100,-16'sd200,16'd300}, t:'{32'd1,32'd2,32'd3}, sf:1'b0, lm:1'b1, te:1'b0},
        // R3: scaled coefficients with shift by 12
        '{m:'{16'h1000,16'd0,16'd0, 16'd0,16'h1000,16'd0, 16'd0,16'd0,16'h1000},
          v:'{16'd5,-16'sd7,16'd9}, t:'{32'd10,-32'sd20,32'd30}, sf:1'b1, lm:1'b0, te:1'b1},
        // R6: full-scale products wrap 32-bit result, IR clamps low
        '{m:'{16'h7FFF,16'h7FFF,16'h7FFF, 16'h8000,16'h7FFF,16'd3, 16'd2,16'h8000,16'd0},
          v:'{16'h7FFF,16'h7FFF,16'h7FFF}, t:'{32'd0,32'd0,32'd0}, sf:1'b0, lm:1'b0, te:1'b0},
        // R4: positive 44-bit overflow on row 0
        '{m:'{16'h8000,16'd0,16'd0, 16'd0,16'd0,16'd0, 16'd0,16'd0,16'd0},
          v:'{16'h8000,16'd0,16'd0}, t:'{32'h7FFFFFFF,32'd0,32'd0}, sf:1'b1, lm:1'b0, te:1'b1},
        // R5, R10: negative overflow on row 0 hides behind a result of -1
        '{m:'{16'd1,16'd0,16'd0, 16'd0,16'd0,16'd0, 16'd0,16'd0,16'd0},
          v:'{-16'sd1,16'd0,16'd0}, t:'{32'h80000000,32'd0,32'd0}, sf:1'b0, lm:1'b0, te:1'b1}
    };

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    function automatic void model(input vec_t e, output logic [95:0] emac,
                                  output logic [47:0] eir, output logic [2:0] eop,
                                  output logic [2:0] eon, output logic [2:0] esat);
        longint acc, sh;
        int m32;
        eop = '0; eon = '0; esat = '0;
        for (int r = 0; r < 3; r++) begin
            acc = e.te ? longint'($signed(e.t[r])) * 64'sd4096 : 64'sd0;
            for (int c = 0; c < 3; c++) begin
                acc += longint'($signed(e.m[r*3+c])) * longint'($signed(e.v[c]));
                if (acc > 64'sd8796093022207) begin
                    eop[r] = 1'b1; acc -= 64'sd17592186044416;
                end else if (acc < -64'sd8796093022208) begin
                    eon[r] = 1'b1; acc += 64'sd17592186044416;
                end
            end
            sh = acc >>> (e.sf ? 12 : 0);
            emac[r*32 +: 32] = sh[31:0];
            m32 = int'(sh[31:0]);
            if (m32 > 32767) begin
                eir[r*16 +: 16] = 16'h7FFF; esat[r] = 1'b1;
            end else if (e.lm && m32 < 0) begin
                eir[r*16 +: 16] = 16'h0000; esat[r] = 1'b1;
            end else if (m32 < -32768) begin
                eir[r*16 +: 16] = 16'h8000; esat[r] = 1'b1;
            end else begin
                eir[r*16 +: 16] = m32[15:0];
            end
        end
    endfunction

    task automatic drive(input vec_t e);
        for (int k = 0; k < 9; k++) mat[k*16 +: 16] = e.m[k];
        for (int k = 0; k < 3; k++) vec[k*16 +: 16] = e.v[k];
        for (int k = 0; k < 3; k++) tr[k*32 +: 32]  = e.t[k];
        sf = e.sf; lm = e.lm; te = e.te;
    endtask

    task automatic finish_up();
        if (!finished) begin
            finished = 1'b1;
            $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(200000.0 * 5.0);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        logic [95:0] emac;
        logic [47:0] eir;
        logic [2:0]  eop, eon, esat;
        logic [95:0] held;
        int cnt;

        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11 busy", 64'(busy), 64'd0);
        chk("R11 done", 64'(done), 64'd0);
        chk("R11 mac",  64'(mac[63:0]) | 64'(mac[95:64]), 64'd0);
        chk("R11 ir/flags", {13'd0, ir, ovp, ovn, sat}, 64'd0);
        rst_n = 1'b1;

        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            drive(TBL[i]);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            chk($sformatf("R8 busy after start, vector %0d", i), 64'(busy), 64'd1);
            cnt = 0;
            while (!done && cnt < 100) begin
                @(negedge clk);
                cnt++;
            end
            model(TBL[i], emac, eir, eop, eon, esat);
            chk($sformatf("R8 latency, vector %0d", i), 64'(cnt), 64'(LAT));
            chk($sformatf("R8 idle at done, vector %0d", i), 64'(busy), 64'd0);
            for (int r = 0; r < 3; r++)
                chk($sformatf("R1/R2/R3 row result %0d, vector %0d", r, i),
                    64'(mac[r*32 +: 32]), 64'(emac[r*32 +: 32]));
            chk($sformatf("R6/R7 clamped results, vector %0d", i), 64'(ir), 64'(eir));
            chk($sformatf("R6/R7 sat flags, vector %0d", i), 64'(sat), 64'(esat));
            chk($sformatf("R4 pos overflow, vector %0d", i), 64'(ovp), 64'(eop));
            chk($sformatf("R5/R10 neg overflow, vector %0d", i), 64'(ovn), 64'(eon));
            @(negedge clk);
            chk($sformatf("R8 done one cycle, vector %0d", i), 64'(done), 64'd0);
        end

        // R9: start pulse in mid-run is ignored
        @(negedge clk);
        drive(TBL[0]);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cnt = 0;
        repeat (3) begin @(negedge clk); cnt++; end
        start = 1'b1;
        @(negedge clk);
        cnt++;
        start = 1'b0;
        while (!done && cnt < 100) begin
            @(negedge clk);
            cnt++;
        end
        model(TBL[0], emac, eir, eop, eon, esat);
        chk("R9 latency unchanged by mid-run start", 64'(cnt), 64'(LAT));
        chk("R9 result unchanged by mid-run start", 64'(mac), 64'(emac));
        @(negedge clk);
        chk("R9 no second run", 64'(busy), 64'd0);

        // R10: idle hold while operands change
        held = mac;
        drive(TBL[3]);
        repeat (5) @(negedge clk);
        chk("R10 results hold while idle", 64'(mac[63:0]) ^ 64'(held[63:0]), 64'd0);
        chk("R10 ir holds while idle", 64'(ir), 64'(eir));

        finish_up();
    end
endmodule